// File: doc/BRIEF.md
# Indirect Register Access Slave Port

This block is the slave side of a host bus that reaches a bank of eight 16-bit control/status registers through two ports. The first port is a pointer register. The second is a data window onto the register the pointer names. The host drives an active-low chip select, a port-select line, an active-low data strobe, a read/write line and a 16-bit data bus. It has no clock in common with the block. The block answers every access with a READY acknowledge. READY is held until the host takes the strobe or the chip select away.

The chip select and the strobe pass through two-flop synchronisers into the system clock domain. A four-state handshake machine then runs the access: idle, access, acknowledge, wait-for-release. The port-select and read/write lines are captured once, when an access starts. Read data is registered, and the bus output enable is raised only while a read is acknowledged. Register 0 holds a power-off flag at bit 2. Reset sets this flag, so the block leaves reset in its powered-off idle state. The system clock should run at least about four times faster than the host strobe rate.

Top module: `regport_slave`

## Requirements
- R1: After reset the pointer is 0, register 0 reads 0x0004, registers 1 to 7 read 0, `host_ready` and `bus_oe` are low, and `pwr_off` is high.
- R2: While `host_cs_n` is high, the block ignores strobes. READY stays low and no register changes.
- R3: With `host_psel` = 1, an access targets the pointer. A write stores the low 4 bits of the bus. A read returns the pointer zero-extended to 16 bits.
- R4: With `host_psel` = 0, an access targets the data port. A write (`host_rd` = 0) stores the bus value into the register the pointer selects. A read (`host_rd` = 1) returns that register.
- R5: When the pointer is 8 to 15, a data-port read returns 0 and a data-port write changes no register.
- R6: On a read, READY rises only once the read value is on `bus_dout`. That value stays valid for as long as READY is high.
- R7: Once raised, READY stays high while both chip select and strobe stay asserted. It falls within 6 system clocks after either one is negated.
- R8: `bus_oe` is high only while a read is acknowledged. It stays low during write acknowledges and when no access is in progress.
- R9: Each strobe assertion yields at most one access. If chip select is negated and then reasserted while the strobe is still low, no new READY appears until the strobe has been released.
- R10: `pwr_off` follows bit 2 of register 0. A data-port write to register 0 can clear it or set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_psel | input | 1 | Port select: 1 = pointer port, 0 = data port |
| host_ds_n | input | 1 | Host data strobe, active low |
| host_rd | input | 1 | 1 = read, 0 = write |
| bus_din | input | 16 | Write data from the host bus |
| bus_dout | output | 16 | Read data toward the host bus |
| bus_oe | output | 1 | Output enable for the bus driver |
| host_ready | output | 1 | Access acknowledge, active high |
| pwr_off | output | 1 | Power-off flag, bit 2 of register 0 |

## Verification
A handshake machine in the wrong state shows at the ports in one of two ways. READY may never rise, which is caught within 20 clocks of a strobe. Or READY may fail to fall within 6 clocks of a release, or may rise again while a strobe is held. A corrupted pointer or register shows on the next read-back in a sweep that writes and reads every index from 0 to 15. A wrong output enable shows as `bus_oe` set on a write acknowledge or while idle, and this is checked on every access.

// File: rtl/regport_pkg.sv
package regport_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_ACK     = 2'd2,
        ST_RELEASE = 2'd3
    } hs_state_e;
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
    parameter int W = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_regs_t;

    sync_regs_t q, d;

    always_comb begin
        d.meta   = async_i;
        d.stable = q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.meta   <= RST_VAL;
            q.stable <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign sync_o = q.stable;
endmodule

// File: rtl/regport_hs.sv
module regport_hs
    import regport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic strobe_i,
    input  logic rd_i,
    input  logic port_i,
    output logic ready_o,
    output logic acc_rd_o,
    output logic acc_port_o,
    output logic wr_stb_o,
    output logic rd_ld_o
);
    typedef struct packed {
        hs_state_e st;
        logic      rd;
        logic      port;
    } hs_regs_t;

    hs_regs_t q, d;
    logic     active;

    assign active = sel_i && strobe_i;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (active) begin
                    d.st   = ST_ACCESS;
                    d.rd   = rd_i;
                    d.port = port_i;
                end
            end
            ST_ACCESS:  d.st = ST_ACK;
            ST_ACK:     if (!active)   d.st = ST_RELEASE;
            ST_RELEASE: if (!strobe_i) d.st = ST_IDLE;
            default:    d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.rd   <= 1'b0;
            q.port <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ready_o    = (q.st == ST_ACK);
    assign acc_rd_o   = q.rd;
    assign acc_port_o = q.port;
    assign wr_stb_o   = (q.st == ST_ACCESS) && !q.rd;
    assign rd_ld_o    = (q.st == ST_ACCESS) && q.rd;

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACK && !active) |=> !ready_o);

    assert_ack_from_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(active, 2));

    assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RELEASE && strobe_i) |=> !ready_o);
endmodule

// File: rtl/regport_regs.sv
module regport_regs #(
    parameter int DATA_W  = 16,
    parameter int NREGS   = 8,
    parameter int PTR_W   = 4,
    parameter int PWR_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we_i,
    input  logic              reg_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              pwr_off_o
);
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

    function automatic logic [NREGS-1:0][DATA_W-1:0] reset_image();
        logic [NREGS-1:0][DATA_W-1:0] v;
        v = '0;
        v[0][PWR_BIT] = 1'b1;
        return v;
    endfunction

    localparam logic [NREGS-1:0][DATA_W-1:0] RST_IMG = reset_image();

    typedef struct packed {
        logic [PTR_W-1:0]              ptr;
        logic [NREGS-1:0][DATA_W-1:0]  regs;
    } rf_regs_t;

    rf_regs_t q, d;
    logic     in_range;

    assign in_range = ({1'b0, q.ptr} < (PTR_W+1)'(NREGS));

    always_comb begin
        d.ptr = ptr_we_i ? wdata_i[PTR_W-1:0] : q.ptr;
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_comb begin
            d.regs[g] = (reg_we_i && q.ptr == PTR_W'(g)) ? wdata_i : q.regs[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ptr  <= '0;
            q.regs <= RST_IMG;
        end else begin
            q <= d;
        end
    end

    assign ptr_o     = q.ptr;
    assign rdata_o   = in_range ? q.regs[q.ptr[IDX_W-1:0]] : '0;
    assign pwr_off_o = q.regs[0][PWR_BIT];

    assert_oor_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && !in_range) |=> $stable(q.regs));

    assert_ptr_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we_i && !reg_we_i) |=> $stable(q.regs));
endmodule

// File: rtl/regport_slave.sv
module regport_slave #(
    parameter int DATA_W  = 16,
    parameter int NREGS   = 8,
    parameter int PTR_W   = 4,
    parameter int PWR_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_psel,
    input  logic              host_ds_n,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic              host_ready,
    output logic              pwr_off
);
    localparam int PAD_W = DATA_W - PTR_W;

    logic [1:0]        n_sync;
    logic              sel_s, strobe_s;
    logic              acc_rd, acc_port, wr_stb, rd_ld;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] reg_rdata;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
    } top_regs_t;

    top_regs_t q, d;

    regport_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({host_cs_n, host_ds_n}),
        .sync_o  (n_sync)
    );

    assign sel_s    = !n_sync[1];
    assign strobe_s = !n_sync[0];

    regport_hs u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_s),
        .strobe_i   (strobe_s),
        .rd_i       (host_rd),
        .port_i     (host_psel),
        .ready_o    (host_ready),
        .acc_rd_o   (acc_rd),
        .acc_port_o (acc_port),
        .wr_stb_o   (wr_stb),
        .rd_ld_o    (rd_ld)
    );

    regport_regs #(
        .DATA_W (DATA_W),
        .NREGS  (NREGS),
        .PTR_W  (PTR_W),
        .PWR_BIT(PWR_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_we_i  (wr_stb && acc_port),
        .reg_we_i  (wr_stb && !acc_port),
        .wdata_i   (bus_din),
        .ptr_o     (ptr),
        .rdata_o   (reg_rdata),
        .pwr_off_o (pwr_off)
    );

    always_comb begin
        d = q;
        if (rd_ld) begin
            d.dout = acc_port ? {{PAD_W{1'b0}}, ptr} : reg_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.dout <= '0;
        else        q <= d;
    end

    assign bus_dout = q.dout;
    assign bus_oe   = host_ready && acc_rd;

    assert_oe_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(rd_ld));

    assert_dout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_dout));

    assert_oe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && !host_ready) |-> !bus_oe);
endmodule

// File: tb/sim_regport_slave.sv
module sim_regport_slave;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs_n = 1'b1;
    logic        host_psel = 1'b0;
    logic        host_ds_n = 1'b1;
    logic        host_rd = 1'b0;
    logic [15:0] bus_din = '0;
    logic [15:0] bus_dout;
    logic        bus_oe;
    logic        host_ready;
    logic        pwr_off;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] model [0:7];

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    regport_slave u0 (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_psel(host_psel),
        .host_ds_n(host_ds_n), .host_rd(host_rd), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .host_ready(host_ready), .pwr_off(pwr_off)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic psel, input logic rd, input logic [15:0] wd,
                          input logic rel_cs, output logic [15:0] rv);
        int n;
        @(negedge clk);
        host_cs_n = 1'b0; host_psel = psel; host_rd = rd; bus_din = wd;
        @(negedge clk);
        host_ds_n = 1'b0;
        n = 0;
        while (!host_ready && n < 20) begin @(negedge clk); n++; end
        check("R7 ready rises", 16'(host_ready), 16'd1);
        check(rd ? "R8 oe on read" : "R8 oe off on write", 16'(bus_oe), 16'(rd));
        rv = bus_dout;
        repeat (3) begin
            @(negedge clk);
            check("R6 data held", bus_dout, rv);
        end
        check("R7 ready held", 16'(host_ready), 16'd1);
        if (rel_cs) host_cs_n = 1'b1; else host_ds_n = 1'b1;
        n = 0;
        while (host_ready && n < 6) begin @(negedge clk); n++; end
        check("R7 ready released", 16'(host_ready), 16'd0);
        host_cs_n = 1'b1; host_ds_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 oe idle", 16'(bus_oe), 16'd0);
    endtask

    initial begin
        while (cycles < 100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        for (int i = 0; i < 8; i++) model[i] = (i == 0) ? 16'h0004 : 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", 16'(host_ready), 16'd0);
        check("R1 oe", 16'(bus_oe), 16'd0);
        check("R1 pwr_off", 16'(pwr_off), 16'd1);
        access(1'b1, 1'b1, 16'h0, 1'b0, rv); check("R1 pointer", rv, 16'h0000);
        for (int i = 0; i < 8; i++) begin
            access(1'b1, 1'b0, 16'(i), 1'b0, rv);
            access(1'b0, 1'b1, 16'h0, 1'b0, rv);
            check("R1 reset value", rv, model[i]);
        end

        // R2: strobes with chip select high are ignored
        access(1'b1, 1'b0, 16'h0003, 1'b0, rv);
        @(negedge clk); host_psel = 1'b0; host_rd = 1'b0; bus_din = 16'hDEAD; host_ds_n = 1'b0;
        repeat (10) begin @(negedge clk); check("R2 no ready", 16'(host_ready), 16'd0); end
        host_ds_n = 1'b1; repeat (3) @(negedge clk);
        access(1'b0, 1'b1, 16'h0, 1'b0, rv); check("R2 reg unchanged", rv, 16'h0000);

        // R3/R4/R5 sweep over all pointer values
        for (int i = 0; i < 16; i++) begin
            logic [15:0] wv;
            wv = 16'((i * 16'h1111) ^ 16'h5AC3) & ((i == 0) ? 16'hFFFB : 16'hFFFF);
            access(1'b1, 1'b0, 16'hFFF0 | 16'(i), i[0], rv);
            access(1'b1, 1'b1, 16'h0, 1'b0, rv);
            check("R3 pointer readback", rv, 16'(i));
            access(1'b0, 1'b0, wv, i[1], rv);
            if (i < 8) model[i] = wv;
            access(1'b0, 1'b1, 16'h0, i[0], rv);
            check(i < 8 ? "R4 data readback" : "R5 out of range zero", rv, (i < 8) ? model[i] : 16'h0);
        end
        for (int i = 0; i < 8; i++) begin
            access(1'b1, 1'b0, 16'(i), 1'b0, rv);
            access(1'b0, 1'b1, 16'h0, 1'b1, rv);
            check("R5 no side effect", rv, model[i]);
        end

        // R10: power-off bit in register 0
        check("R10 pwr_off cleared", 16'(pwr_off), 16'd0);
        access(1'b1, 1'b0, 16'h0, 1'b0, rv);
        access(1'b0, 1'b0, 16'h0004, 1'b0, rv);
        check("R10 pwr_off set", 16'(pwr_off), 16'd1);
        access(1'b0, 1'b0, 16'h0000, 1'b0, rv);
        check("R10 pwr_off clear", 16'(pwr_off), 16'd0);

        // R9: chip select bounce with strobe held low
        @(negedge clk); host_cs_n = 1'b0; host_psel = 1'b1; host_rd = 1'b1;
        @(negedge clk); host_ds_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R9 first ready", 16'(host_ready), 16'd1);
        host_cs_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 released", 16'(host_ready), 16'd0);
        host_cs_n = 1'b0;
        repeat (10) begin @(negedge clk); check("R9 no retrigger", 16'(host_ready), 16'd0); end
        host_ds_n = 1'b1; host_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        access(1'b1, 1'b1, 16'h0, 1'b0, rv); check("R9 next access ok", rv, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule